// File: doc/BRIEF.md
# Header-Decoded SPI Register Access Slave

This block is the serial front end of a radio-style peripheral. A host drives a four-wire SPI bus in mode 0, MSB first. Every access opens with one header byte: bit 7 is the read flag (1 = read), bit 6 is the burst flag, and bits 5:0 are the address. The header picks one of three targets. Addresses 0x00 to 0x2F are a bank of read/write configuration bytes. Addresses 0x30 to 0x3D hold read-only status bytes when the burst flag is 1 and command strobes when it is 0. The configuration bank is exposed to the core as a flat vector. Status bytes come in from the core on a flat input. Strobes leave the block as one-clock pulses.

The SPI pins are brought into the system clock domain through synchronisers, and all logic runs on the system clock. While the header byte and any write data bytes are shifted in, the block returns the core's chip status byte on the serial output. A burst keeps advancing an internal address counter one byte at a time until chip select rises. The power-down and oscillator-off strobes are held back until chip select is released.

Top module: `spi_hdr_regif`

## Requirements
- R1: While reset is asserted and just after it, `strobeOut` is all zero, every configuration byte is 0x00, and `misoOut` is 0.
- R2: A header with bit 7 = 0 and bit 6 = 0 and an address of 0x00–0x2F writes the next byte to that configuration address. With bit 7 = 1 it instead returns that byte on the following byte slot. After one data byte, the next byte in the same chip-select window is a new header.
- R3: A header with bit 6 = 1 and an address of 0x00–0x2F starts a burst. Each further data byte goes to, or comes from, the next address, and 0x2F is followed by 0x00. The burst continues until chip select rises.
- R4: During a header byte, and during every write data byte, `misoOut` shifts out `statusIn`. The bit order is MSB first, with data changing after the falling SCLK edge, so it is valid at the rising edge.
- R5: A header with bit 7 = 1, bit 6 = 1 and address 0x30+k (k = 0..13) returns byte k of `statRegsIn` (bits 8k+7:8k) for exactly one byte. The byte after it is a new header.
- R6: A header with bit 7 = 0, bit 6 = 1 and an address of 0x30–0x3D consumes one data byte and changes no configuration byte.
- R7: A header with bit 7 = 0, bit 6 = 0 and address 0x30+k gives a single pulse on `strobeOut[k]` for every k except 2 and 9. The pulse comes while chip select is still low, and the next byte in the same window is a new header.
- R8: Strobes 2 (0x32, oscillator off) and 9 (0x39, power down) do not pulse while chip select is low. After chip select rises, each pending one pulses once, lowest index first.
- R9: At most one bit of `strobeOut` is high in any clock, and every pulse lasts exactly one system clock.
- R10: A byte left incomplete when chip select rises is discarded. It causes no write and no strobe.
- R11: Addresses 0x3E and 0x3F, and a header with bit 7 = 1 and bit 6 = 0 at 0x30–0x3D, read back 0x00 for one byte. Writes there are ignored, and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | SPI serial clock, asynchronous |
| csNIn | input | 1 | SPI chip select, active low, asynchronous |
| mosiIn | input | 1 | SPI serial data in |
| misoOut | output | 1 | SPI serial data out |
| statusIn | input | 8 | Chip status byte returned during headers and writes |
| statRegsIn | input | 112 | Fourteen read-only status bytes, byte k at bits 8k+7:8k |
| strobeOut | output | 14 | One-hot command strobe pulses |
| cfgRegsOut | output | 384 | Forty-eight configuration bytes, byte a at bits 8a+7:8a |

## Verification
The strobe assertions assume that SCLK is many system clocks long per phase. They also assume that chip select stays low for several system clocks after the last rising SCLK edge, so an immediate strobe always lands while the synchronised chip select is still low. The stimulus holds each SCLK phase for eight system clocks. It holds chip select low for eight clocks before the first edge and after the last one, and it leaves twelve idle clocks after each release so that deferred strobes drain before the next window. `statusIn` and `statRegsIn` are held constant, which keeps the captured status byte deterministic.

// File: rtl/spi_hdr_pkg.sv
package spi_hdr_pkg;
  localparam int HDR_ADDR_W = 6;
  localparam int STRB_IDX_W = 4;
  localparam logic [HDR_ADDR_W-1:0] STRB_BASE = 6'h30;
  localparam logic [HDR_ADDR_W-1:0] NULL_ADDR = 6'h3F;

  typedef struct packed {
    logic                  txLoadStatus;
    logic                  txLoadNext;
    logic                  txShift;
    logic                  nextCapture;
    logic                  nextIsRead;
    logic [HDR_ADDR_W-1:0] rdAddr;
    logic                  wrEn;
    logic [HDR_ADDR_W-1:0] wrAddr;
    logic [7:0]            wrData;
    logic                  strbEn;
    logic                  strbDefer;
    logic [STRB_IDX_W-1:0] strbIdx;
    logic                  csIdle;
  } ctrlBus_t;
endpackage

// File: rtl/spi_hdr_ctrl.sv
module spi_hdr_ctrl
  import spi_hdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CFG     = 48,
  parameter int NUM_STAT    = 14,
  parameter int DEFER_A     = 2,
  parameter int DEFER_B     = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclkIn,
  input  logic     csNIn,
  input  logic     mosiIn,
  output ctrlBus_t ctrl
);
  localparam logic [HDR_ADDR_W-1:0] CFG_LAST  = HDR_ADDR_W'(NUM_CFG - 1);
  localparam logic [HDR_ADDR_W-1:0] STRB_LAST = HDR_ADDR_W'(int'(STRB_BASE) + NUM_STAT - 1);

  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, mosiPipe;
  logic sclkS, csS, mosiS, sclkPrev, csPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csNIn};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  assign sclkS = sclkPipe[SYNC_STAGES-1];
  assign csS   = csPipe[SYNC_STAGES-1];
  assign mosiS = mosiPipe[SYNC_STAGES-1];

  logic sclkRise, sclkFall, csFall, byteDone;
  logic [2:0] bitCnt;
  logic [6:0] shiftIn;
  logic inData, isRead, isBurst;
  logic [HDR_ADDR_W-1:0] addrCnt, addrInc, hAddr;
  logic [7:0] rxByte;
  logic hRead, hBurst, hIsCfg, hIsHigh, hStrobe;
  logic [STRB_IDX_W-1:0] hIdx;

  assign sclkRise = sclkS & ~sclkPrev & ~csS;
  assign sclkFall = ~sclkS & sclkPrev & ~csS;
  assign csFall   = ~csS & csPrev;
  assign byteDone = sclkRise && (bitCnt == 3'd7);
  assign rxByte   = {shiftIn, mosiS};
  assign hRead    = rxByte[7];
  assign hBurst   = rxByte[6];
  assign hAddr    = rxByte[HDR_ADDR_W-1:0];
  assign hIsCfg   = hAddr <= CFG_LAST;
  assign hIsHigh  = (hAddr >= STRB_BASE) && (hAddr <= STRB_LAST);
  assign hStrobe  = hIsHigh && !hRead && !hBurst;
  assign hIdx     = STRB_IDX_W'(hAddr - STRB_BASE);
  assign addrInc  = (addrCnt == CFG_LAST) ? '0 : addrCnt + 1'b1;

  always_comb begin
    ctrl              = '0;
    ctrl.csIdle       = csS;
    ctrl.txLoadStatus = csFall;
    ctrl.txShift      = sclkFall && (bitCnt != 3'd0);
    ctrl.txLoadNext   = sclkFall && (bitCnt == 3'd0);
    ctrl.wrAddr       = addrCnt;
    ctrl.wrData       = rxByte;
    ctrl.rdAddr       = hAddr;
    ctrl.strbIdx      = hIdx;
    if (byteDone) begin
      ctrl.nextCapture = 1'b1;
      if (!inData) begin
        if (hStrobe) begin
          ctrl.strbEn    = 1'b1;
          ctrl.strbDefer = (hIdx == STRB_IDX_W'(DEFER_A)) || (hIdx == STRB_IDX_W'(DEFER_B));
        end else begin
          ctrl.nextIsRead = hRead;
          if (hIsHigh && !hBurst) ctrl.rdAddr = NULL_ADDR;
        end
      end else begin
        ctrl.wrEn       = !isRead && (addrCnt <= CFG_LAST);
        ctrl.nextIsRead = isRead && isBurst;
        ctrl.rdAddr     = addrInc;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
      inData  <= 1'b0;
      isRead  <= 1'b0;
      isBurst <= 1'b0;
      addrCnt <= '0;
    end else if (csS) begin
      bitCnt <= '0;
      inData <= 1'b0;
    end else if (sclkRise) begin
      shiftIn <= {shiftIn[5:0], mosiS};
      bitCnt  <= bitCnt + 3'd1;
      if (byteDone) begin
        if (!inData) begin
          if (!hStrobe) begin
            inData  <= 1'b1;
            isRead  <= hRead;
            isBurst <= hBurst && hIsCfg;
            addrCnt <= hAddr;
          end
        end else if (isBurst) begin
          addrCnt <= addrInc;
        end else begin
          inData <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_hdr_dpath.sv
module spi_hdr_dpath
  import spi_hdr_pkg::*;
#(
  parameter int NUM_CFG  = 48,
  parameter int NUM_STAT = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlBus_t              ctrl,
  input  logic [7:0]            statusIn,
  input  logic [NUM_STAT*8-1:0] statRegsIn,
  output logic                  misoOut,
  output logic [NUM_STAT-1:0]   strobeOut,
  output logic [NUM_CFG*8-1:0]  cfgRegsOut
);
  localparam logic [HDR_ADDR_W-1:0] CFG_LAST  = HDR_ADDR_W'(NUM_CFG - 1);
  localparam logic [HDR_ADDR_W-1:0] STRB_LAST = HDR_ADDR_W'(int'(STRB_BASE) + NUM_STAT - 1);
  localparam logic [NUM_STAT-1:0]   ONE_BIT   = NUM_STAT'(1);

  logic [7:0] cfgMem  [NUM_CFG];
  logic [7:0] statArr [NUM_STAT];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfgOut
    assign cfgRegsOut[g*8 +: 8] = cfgMem[g];
  end
  for (genvar g = 0; g < NUM_STAT; g++) begin : g_statIn
    assign statArr[g] = statRegsIn[g*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CFG; i++) cfgMem[i] <= '0;
    end else if (ctrl.wrEn) begin
      cfgMem[ctrl.wrAddr] <= ctrl.wrData;
    end
  end

  logic [7:0] rdData, nextByte, txReg;
  logic [STRB_IDX_W-1:0] statIdx;
  assign statIdx = STRB_IDX_W'(ctrl.rdAddr - STRB_BASE);

  always_comb begin
    rdData = 8'h00;
    if (ctrl.rdAddr <= CFG_LAST) rdData = cfgMem[ctrl.rdAddr];
    else if (ctrl.rdAddr >= STRB_BASE && ctrl.rdAddr <= STRB_LAST) rdData = statArr[statIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextByte <= '0;
      txReg    <= '0;
    end else begin
      if (ctrl.nextCapture) nextByte <= ctrl.nextIsRead ? rdData : statusIn;
      if (ctrl.txLoadStatus)    txReg <= statusIn;
      else if (ctrl.txLoadNext) txReg <= nextByte;
      else if (ctrl.txShift)    txReg <= {txReg[6:0], 1'b0};
    end
  end
  assign misoOut = txReg[7];

  logic [NUM_STAT-1:0] pend, lowBit;
  assign lowBit = pend & (~pend + ONE_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeOut <= '0;
      pend      <= '0;
    end else begin
      strobeOut <= '0;
      if (ctrl.strbEn && !ctrl.strbDefer) begin
        strobeOut <= ONE_BIT << ctrl.strbIdx;
      end else if (ctrl.csIdle && pend != '0) begin
        strobeOut <= lowBit;
        pend      <= pend & ~lowBit;
      end
      if (ctrl.strbEn && ctrl.strbDefer) pend <= pend | (ONE_BIT << ctrl.strbIdx);
    end
  end
endmodule

// File: rtl/spi_hdr_regif.sv
module spi_hdr_regif
  import spi_hdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CFG     = 48,
  parameter int NUM_STAT    = 14,
  parameter int DEFER_A     = 2,
  parameter int DEFER_B     = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclkIn,
  input  logic                  csNIn,
  input  logic                  mosiIn,
  output logic                  misoOut,
  input  logic [7:0]            statusIn,
  input  logic [NUM_STAT*8-1:0] statRegsIn,
  output logic [NUM_STAT-1:0]   strobeOut,
  output logic [NUM_CFG*8-1:0]  cfgRegsOut
);
  ctrlBus_t ctrl;
  logic     csSync;
  assign csSync = ctrl.csIdle;

  spi_hdr_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT),
    .DEFER_A(DEFER_A), .DEFER_B(DEFER_B)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .mosiIn(mosiIn), .ctrl(ctrl)
  );

  spi_hdr_dpath #(.NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT)) dpath_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .statusIn(statusIn), .statRegsIn(statRegsIn),
    .misoOut(misoOut), .strobeOut(strobeOut), .cfgRegsOut(cfgRegsOut)
  );
endmodule

// File: rtl/spi_hdr_regif_chk.sv
module spi_hdr_regif_chk #(
  parameter int NUM_STAT = 14,
  parameter int DEFER_A  = 2,
  parameter int DEFER_B  = 9
) (
  input logic                clk,
  input logic                rstN,
  input logic                csSync,
  input logic [NUM_STAT-1:0] strobeOut
);
  localparam logic [NUM_STAT-1:0] DEFER_MASK =
    (NUM_STAT'(1) << DEFER_A) | (NUM_STAT'(1) << DEFER_B);

  // R9: never two strobes in the same clock
  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeOut));

  // R9: a strobe bit that is high drops on the following clock
  p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOut != '0) |=> ((strobeOut & $past(strobeOut)) == '0));

  // R8: held-back strobes only after chip select is released
  p_defer_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((strobeOut & DEFER_MASK) != '0) |-> csSync);

  // R7: the other strobes fire inside the chip-select window
  p_immediate_active_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((strobeOut & ~DEFER_MASK) != '0) |-> !csSync);
endmodule

bind spi_hdr_regif spi_hdr_regif_chk #(
  .NUM_STAT(NUM_STAT), .DEFER_A(DEFER_A), .DEFER_B(DEFER_B)
) chk_i (
  .clk(clk), .rstN(rstN), .csSync(csSync), .strobeOut(strobeOut)
);

// File: tb/spi_hdr_regif_tb_top.sv
module spi_hdr_regif_tb_top;
  localparam int NCFG  = 48;
  localparam int NSTAT = 14;
  localparam int HALF  = 8;
  localparam logic [7:0] STAT = 8'hA5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NSTAT*8-1:0] statRegs;
  logic [NSTAT-1:0]   strobeOut;
  logic [NCFG*8-1:0]  cfgOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [NCFG];
  int expQ[$];
  string expR[$];
  bit [NSTAT-1:0] defPend = '0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    assign statRegs[g*8 +: 8] = 8'h80 + 8'(g);
  end

  spi_hdr_regif dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN), .mosiIn(mosi), .misoOut(miso),
    .statusIn(STAT), .statRegsIn(statRegs), .strobeOut(strobeOut), .cfgRegsOut(cfgOut)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // strobe monitor: every clock, compared against the expected pulse queue
  always @(negedge clk) begin
    if (rstN && strobeOut != '0) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7/R8/R10/R11", "unexpected strobe", int'(strobeOut), 0);
      end else begin
        automatic int e = expQ.pop_front();
        automatic string r = expR.pop_front();
        chk(strobeOut == (NSTAT'(1) << e), r, "strobe vector", int'(strobeOut), 1 << e);
      end
    end
  end

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic csLow();
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    for (int i = 0; i < NSTAT; i++)
      if (defPend[i]) begin expQ.push_back(i); expR.push_back("R8"); end
    defPend = '0;
    repeat (12) @(negedge clk);
  endtask

  task automatic cmpCfg(input string req);
    automatic int bad = -1;
    for (int i = NCFG - 1; i >= 0; i--) if (cfgOut[i*8 +: 8] !== model[i]) bad = i;
    if (bad < 0) chk(1'b1, req, "cfg bank", 0, 0);
    else chk(1'b0, req, $sformatf("cfg byte %0d", bad), int'(cfgOut[bad*8 +: 8]), int'(model[bad]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < NCFG; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(strobeOut == '0, "R1", "strobe in reset", int'(strobeOut), 0);
    chk(miso == 1'b0, "R1", "miso in reset", int'(miso), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    cmpCfg("R1");

    // R2/R4: single write then single read
    csLow();
    xfer(8'h05, rx); chk(rx == STAT, "R4", "status on header", int'(rx), int'(STAT));
    xfer(8'h3C, rx); chk(rx == STAT, "R4", "status on write data", int'(rx), int'(STAT));
    csHigh(); model[5] = 8'h3C; cmpCfg("R2");
    csLow();
    xfer(8'h85, rx); chk(rx == STAT, "R4", "status on read header", int'(rx), int'(STAT));
    xfer(8'h00, rx); chk(rx == 8'h3C, "R2", "single read 0x05", int'(rx), 8'h3C);
    xfer(8'h06, rx); chk(rx == STAT, "R2", "new header after single", int'(rx), int'(STAT));
    xfer(8'h11, rx);
    csHigh(); model[6] = 8'h11; cmpCfg("R2");

    // R3: burst write across the wrap, then burst read
    csLow();
    xfer(8'h6E, rx);
    xfer(8'hA1, rx); xfer(8'hA2, rx); xfer(8'hA3, rx);
    chk(rx == STAT, "R4", "status on burst write", int'(rx), int'(STAT));
    csHigh(); model[46] = 8'hA1; model[47] = 8'hA2; model[0] = 8'hA3; cmpCfg("R3");
    csLow();
    xfer(8'hEE, rx);
    xfer(8'h00, rx); chk(rx == 8'hA1, "R3", "burst read 0x2E", int'(rx), 8'hA1);
    xfer(8'h00, rx); chk(rx == 8'hA2, "R3", "burst read 0x2F", int'(rx), 8'hA2);
    xfer(8'h00, rx); chk(rx == 8'hA3, "R3", "burst read wrap 0x00", int'(rx), 8'hA3);
    xfer(8'h00, rx); chk(rx == model[1], "R3", "burst read 0x01", int'(rx), int'(model[1]));
    csHigh();

    // R7/R5: immediate strobes and status register reads in one window
    csLow();
    expQ.push_back(0); expR.push_back("R7"); xfer(8'h30, rx);
    expQ.push_back(1); expR.push_back("R7"); xfer(8'h31, rx);
    chk(rx == STAT, "R7", "header after strobe", int'(rx), int'(STAT));
    xfer(8'hF5, rx); xfer(8'h00, rx); chk(rx == 8'h85, "R5", "status reg 5", int'(rx), 8'h85);
    xfer(8'hF6, rx); chk(rx == STAT, "R5", "header after status read", int'(rx), int'(STAT));
    xfer(8'h00, rx); chk(rx == 8'h86, "R5", "status reg 6", int'(rx), 8'h86);
    csHigh();
    chk(expQ.size() == 0, "R7", "strobes delivered", expQ.size(), 0);

    // R8: held-back strobes
    csLow();
    defPend[9] = 1'b1; xfer(8'h39, rx);
    defPend[2] = 1'b1; xfer(8'h32, rx);
    expQ.push_back(4); expR.push_back("R7"); xfer(8'h34, rx);
    repeat (20) @(negedge clk);
    chk(expQ.size() == 0, "R8", "only immediate strobe while selected", expQ.size(), 0);
    csHigh();
    chk(expQ.size() == 0, "R8", "deferred strobes delivered", expQ.size(), 0);

    // R6: write to status address ignored
    csLow();
    xfer(8'h75, rx); xfer(8'hFF, rx); chk(rx == STAT, "R6", "status on ignored write", int'(rx), int'(STAT));
    csHigh(); cmpCfg("R6");
    csLow(); xfer(8'hF5, rx); xfer(8'h00, rx);
    chk(rx == 8'h85, "R6", "status reg unchanged", int'(rx), 8'h85);
    csHigh();

    // R10: partial bytes discarded
    csLow(); xferBits(8'h30, 7, rx); csHigh();
    csLow(); xfer(8'h07, rx); xferBits(8'h5A, 5, rx); csHigh();
    cmpCfg("R10");
    csLow(); xfer(8'h87, rx); xfer(8'h00, rx);
    chk(rx == 8'h00, "R10", "partial write dropped", int'(rx), 0);
    csHigh();
    chk(expQ.size() == 0, "R10", "no strobe from partial header", expQ.size(), 0);

    // R11: null addresses
    csLow(); xfer(8'hBE, rx); xfer(8'h00, rx);
    chk(rx == 8'h00, "R11", "read 0x3E", int'(rx), 0);
    xfer(8'hB3, rx); xfer(8'h00, rx);
    chk(rx == 8'h00, "R11", "read strobe addr no burst", int'(rx), 0);
    xfer(8'h3F, rx); xfer(8'h77, rx);
    csHigh(); cmpCfg("R11");
    chk(expQ.size() == 0, "R11", "no strobe from null access", expQ.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule